// File: doc/BRIEF.md
# Thermal Boot Gate and Watchdog Sequencer

This block runs once after every power-on reset and decides whether the rest of the device may start. In its first cycle out of reset it looks at a single level meaning "some temperature sensor is still above its cooled threshold". It can also look at a retained hot flag, when the caller enables that. If the device is cool, boot is released at once. If it is still hot, boot is held and an external watchdog is handled in one of three ways while the device cools: switched off, given a longer timeout, or kicked at a fixed interval. Without this, a watchdog timeout could restart a device that is still hot, and the device would go straight back into thermal reset.

Once the hot level has stayed low for a programmed number of consecutive cycles, the sequencer clears the retained hot flag and puts the watchdog back to its normal enabled setting. It then either releases boot or asks for a fresh power-on reset, as selected. All inputs are plain control levels. There is no data stream, so there is no valid/ready handshake.

Top module: `thermboot_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `boot_release_o`, `reset_req_o`, `wd_kick_o` and `hot_flag_clr_o` are low, `wd_en_o` equals parameter `WD_EN_RST` (default 1), and `wd_tmo_o` equals `wd_normal_tmo_i`.
- R2: The entry check takes place on the first clock edge after reset is released. If `hot_i` is low there, and either `flag_check_en_i` or `hot_flag_i` is low, `boot_release_o` is high from the next cycle, and no kick or flag clear occurs.
- R3: If `hot_i` is high at the entry check, or `flag_check_en_i` and `hot_flag_i` are both high, the block enters a hold. During the hold, boot release and reset request stay low.
- R4: With `wd_mode_i` = 2'b00 or 2'b11 sampled at the entry check, `wd_en_o` is low throughout the hold.
- R5: With `wd_mode_i` = 2'b01, `wd_en_o` stays high throughout the hold and `wd_tmo_o` equals `wd_backoff_tmo_i`.
- R6: With `wd_mode_i` = 2'b10, `wd_en_o` stays high and `wd_kick_o` gives one-cycle pulses, one every `kick_interval_i` cycles of hold, the first in the `kick_interval_i`-th hold cycle. A value of 0 acts as 1. No kick occurs outside the hold.
- R7: The hold ends only after `hot_i` has been sampled low on `settle_cycles_i` consecutive edges (0 acts as 1). Any high sample restarts the count.
- R8: When the hold ends, `hot_flag_clr_o` pulses for exactly one cycle, in the cycle after the last settling edge. From that cycle on, `wd_en_o` is high and `wd_tmo_o` equals `wd_normal_tmo_i`.
- R9: In the cycle after the flag clear, `reset_req_o` rises if `post_cool_por_i` (sampled at the entry check) is high; otherwise `boot_release_o` rises. Either output stays high until reset, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| hot_i | input | 1 | High while any sensor is above its cooled threshold |
| hot_flag_i | input | 1 | Retained hot-status bit |
| flag_check_en_i | input | 1 | Also treat the retained bit as hot at the entry check |
| wd_mode_i | input | 2 | Watchdog handling during hold: 00/11 off, 01 longer timeout, 10 kick |
| post_cool_por_i | input | 1 | After cooling, 1 requests power-on reset, 0 releases boot |
| wd_normal_tmo_i | input | TMO_W | Normal watchdog timeout setting |
| wd_backoff_tmo_i | input | TMO_W | Longer timeout used in mode 01 |
| kick_interval_i | input | CNT_W | Cycles between kicks in mode 10 |
| settle_cycles_i | input | CNT_W | Consecutive cool cycles required |
| boot_release_o | output | 1 | Boot may proceed |
| reset_req_o | output | 1 | Request for a fresh power-on reset |
| wd_en_o | output | 1 | External watchdog enable |
| wd_tmo_o | output | TMO_W | Timeout setting driven to the watchdog |
| wd_kick_o | output | 1 | One-cycle watchdog service pulse |
| hot_flag_clr_o | output | 1 | One-cycle clear of the retained hot bit |

## Verification
The sequencer is driven with hot-level profiles of several kinds: cool at entry; hot for a random length and then cool; and hot, a short cool gap below the settle count, hot again, then cool. Comparing the second and third kinds shows whether the settle counter restarts rather than adding up cool cycles. A cool level with the retained flag set and enabled separates flag handling from sensor handling. Each profile is crossed with all four mode codes, both exit choices and settle and kick values of zero, one and larger. Kick counts and the cycles of the flag clear and the release then show interval, off-by-one and clamping faults.

// File: rtl/thermboot_pkg.sv
package thermboot_pkg;
  typedef enum logic [2:0] {
    ST_ENTRY   = 3'd0,
    ST_HOLD    = 3'd1,
    ST_CLEAR   = 3'd2,
    ST_RELEASE = 3'd3,
    ST_PORREQ  = 3'd4
  } tb_state_e;

  typedef enum logic [1:0] {
    WD_OFF     = 2'b00,
    WD_BACKOFF = 2'b01,
    WD_FEED    = 2'b10,
    WD_OFF_ALT = 2'b11
  } wd_mode_e;
endpackage

// File: rtl/thermboot_cycle_timer.sv
module thermboot_cycle_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim_eff;

  assign lim_eff = (limit == '0) ? W'(1) : limit;
  assign hit     = run && (cnt_q == lim_eff - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || hit)  cnt_q <= '0;
    else                   cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/thermboot_wd_ctl.sv
module thermboot_wd_ctl
  import thermboot_pkg::*;
#(
  parameter int   TMO_W     = 16,
  parameter logic WD_EN_RST = 1'b1
) (
  input  tb_state_e          state,
  input  wd_mode_e           mode,
  input  logic [TMO_W-1:0]   normal_tmo,
  input  logic [TMO_W-1:0]   backoff_tmo,
  output logic               wd_en,
  output logic [TMO_W-1:0]   wd_tmo
);
  always_comb begin
    wd_en  = 1'b1;
    wd_tmo = normal_tmo;
    unique case (state)
      ST_ENTRY: wd_en = WD_EN_RST;
      ST_HOLD: begin
        unique case (mode)
          WD_BACKOFF: wd_tmo = backoff_tmo;
          WD_FEED:    wd_en  = 1'b1;
          default:    wd_en  = 1'b0;
        endcase
      end
      default: wd_en = 1'b1;
    endcase
  end
endmodule

// File: rtl/thermboot_gate.sv
module thermboot_gate
  import thermboot_pkg::*;
#(
  parameter int   TMO_W     = 16,
  parameter int   CNT_W     = 16,
  parameter logic WD_EN_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hot_i,
  input  logic             hot_flag_i,
  input  logic             flag_check_en_i,
  input  logic [1:0]       wd_mode_i,
  input  logic             post_cool_por_i,
  input  logic [TMO_W-1:0] wd_normal_tmo_i,
  input  logic [TMO_W-1:0] wd_backoff_tmo_i,
  input  logic [CNT_W-1:0] kick_interval_i,
  input  logic [CNT_W-1:0] settle_cycles_i,
  output logic             boot_release_o,
  output logic             reset_req_o,
  output logic             wd_en_o,
  output logic [TMO_W-1:0] wd_tmo_o,
  output logic             wd_kick_o,
  output logic             hot_flag_clr_o
);
  tb_state_e state_q, state_d;
  wd_mode_e  mode_q;
  logic      por_q;
  logic      entry_hot;
  logic      settle_hit;
  logic      kick_hit;
  logic      in_hold;

  assign entry_hot = hot_i || (flag_check_en_i && hot_flag_i);
  assign in_hold   = (state_q == ST_HOLD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ENTRY: state_d = entry_hot ? ST_HOLD : ST_RELEASE;
      ST_HOLD:  if (settle_hit) state_d = ST_CLEAR;
      ST_CLEAR: state_d = por_q ? ST_PORREQ : ST_RELEASE;
      default:  state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ENTRY;
      mode_q  <= WD_OFF;
      por_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_ENTRY) begin
        mode_q <= wd_mode_e'(wd_mode_i);
        por_q  <= post_cool_por_i;
      end
    end
  end

  thermboot_cycle_timer #(.W(CNT_W)) settle_tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_hold && !hot_i),
    .limit (settle_cycles_i),
    .hit   (settle_hit)
  );

  thermboot_cycle_timer #(.W(CNT_W)) kick_tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_hold && (mode_q == WD_FEED)),
    .limit (kick_interval_i),
    .hit   (kick_hit)
  );

  thermboot_wd_ctl #(.TMO_W(TMO_W), .WD_EN_RST(WD_EN_RST)) wd_ctl_i (
    .state       (state_q),
    .mode        (mode_q),
    .normal_tmo  (wd_normal_tmo_i),
    .backoff_tmo (wd_backoff_tmo_i),
    .wd_en       (wd_en_o),
    .wd_tmo      (wd_tmo_o)
  );

  assign wd_kick_o      = kick_hit;
  assign boot_release_o = (state_q == ST_RELEASE);
  assign reset_req_o    = (state_q == ST_PORREQ);
  assign hot_flag_clr_o = (state_q == ST_CLEAR);
endmodule

// File: rtl/thermboot_gate_chk.sv
module thermboot_gate_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] kick_interval_i,
  input logic             boot_release_o,
  input logic             reset_req_o,
  input logic             wd_en_o,
  input logic             wd_kick_o,
  input logic             hot_flag_clr_o
);
  assert_exclusive_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(boot_release_o && reset_req_o));

  assert_boot_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    boot_release_o |=> boot_release_o);

  assert_req_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |=> reset_req_o);

  assert_kick_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_kick_o && kick_interval_i > 1) |=> !wd_kick_o);

  assert_kick_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_kick_o |-> (wd_en_o && !boot_release_o && !reset_req_o));

  assert_clear_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hot_flag_clr_o |=> (!hot_flag_clr_o && (boot_release_o || reset_req_o)));

  assert_clear_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hot_flag_clr_o |-> wd_en_o);

  assert_exit_after_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req_o) |-> $past(hot_flag_clr_o));
endmodule

bind thermboot_gate thermboot_gate_chk #(.CNT_W(CNT_W)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .kick_interval_i (kick_interval_i),
  .boot_release_o  (boot_release_o),
  .reset_req_o     (reset_req_o),
  .wd_en_o         (wd_en_o),
  .wd_kick_o       (wd_kick_o),
  .hot_flag_clr_o  (hot_flag_clr_o)
);

// File: tb/thermboot_gate_tb_top.sv
`timescale 1ns/1ps
module thermboot_gate_tb_top;
  localparam int TMO_W = 16;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             hot_i = 1'b0;
  logic             hot_flag_i = 1'b0;
  logic             flag_check_en_i = 1'b0;
  logic [1:0]       wd_mode_i = 2'b00;
  logic             post_cool_por_i = 1'b0;
  logic [TMO_W-1:0] wd_normal_tmo_i = 16'h0400;
  logic [TMO_W-1:0] wd_backoff_tmo_i = 16'h4000;
  logic [CNT_W-1:0] kick_interval_i = 16'd3;
  logic [CNT_W-1:0] settle_cycles_i = 16'd4;
  logic             boot_release_o, reset_req_o, wd_en_o, wd_kick_o, hot_flag_clr_o;
  logic [TMO_W-1:0] wd_tmo_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  thermboot_gate #(.TMO_W(TMO_W), .CNT_W(CNT_W)) dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic bit hot_at(input int e, input int hlen, input int gap);
    if (e <= hlen) return 1'b1;
    if (gap > 0 && e <= hlen + gap) return 1'b0;
    if (gap > 0 && e <= hlen + gap + 2) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_case(input int hlen, input int gap, input int mode, input bit por,
                          input int settle, input int intv, input bit fen, input bit flag);
    int last, s, iv, exp_clr, exp_done, exp_kicks;
    int kicks, clr_cnt, first_clr, first_boot, first_req;
    bit held;
    s = eff(settle);
    iv = eff(intv);
    last = (gap > 0) ? hlen + gap + 2 : hlen;
    held = (hlen >= 1) || (fen && flag);
    exp_clr = held ? ((last > 1 ? last : 1) + s) : -1;
    exp_done = held ? exp_clr + 1 : 1;
    exp_kicks = (held && mode == 2) ? (exp_clr - 1) / iv : 0;
    kicks = 0; clr_cnt = 0; first_clr = -1; first_boot = -1; first_req = -1;

    @(negedge clk);
    rst_n = 1'b0;
    wd_mode_i = mode[1:0];
    post_cool_por_i = por;
    settle_cycles_i = CNT_W'(settle);
    kick_interval_i = CNT_W'(intv);
    flag_check_en_i = fen;
    hot_flag_i = flag;
    hot_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs during reset
    check(!boot_release_o && !reset_req_o && !wd_kick_o && !hot_flag_clr_o && wd_en_o,
          "R1 in-reset", {boot_release_o, reset_req_o, wd_kick_o, hot_flag_clr_o, wd_en_o}, 1);
    hot_i = hot_at(1, hlen, gap);
    rst_n = 1'b1;
    #0.5;
    check(!boot_release_o && !reset_req_o && wd_en_o && wd_tmo_o == wd_normal_tmo_i,
          "R1 after-release", {boot_release_o, reset_req_o, wd_en_o}, 1);

    for (int c = 1; c <= exp_done + 3; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (wd_kick_o) kicks++;
      if (hot_flag_clr_o) begin
        clr_cnt++;
        if (first_clr < 0) first_clr = c;
      end
      if (boot_release_o && first_boot < 0) first_boot = c;
      if (reset_req_o && first_req < 0) first_req = c;
      if (held && c == 1) begin
        // R3 hold keeps boot low; R4/R5/R6 watchdog handling
        check(!boot_release_o && !reset_req_o, "R3 hold", boot_release_o, 0);
        if (mode == 0 || mode == 3)
          check(!wd_en_o, "R4 wd off in hold", wd_en_o, 0);
        else if (mode == 1)
          check(wd_en_o && wd_tmo_o == wd_backoff_tmo_i, "R5 backoff", int'(wd_tmo_o), int'(wd_backoff_tmo_i));
        else
          check(wd_en_o && wd_tmo_o == wd_normal_tmo_i, "R6 feed enable", int'(wd_en_o), 1);
      end
      if (held && c == exp_clr)
        check(wd_en_o && wd_tmo_o == wd_normal_tmo_i, "R8 restore", int'(wd_tmo_o), int'(wd_normal_tmo_i));
      hot_i = hot_at(c + 1, hlen, gap);
    end

    check(kicks == exp_kicks, "R6 kick count", kicks, exp_kicks);
    if (!held) begin
      check(first_boot == 1 && first_req < 0 && clr_cnt == 0, "R2 immediate boot", first_boot, 1);
    end else begin
      check(first_clr == exp_clr, "R7 settle timing", first_clr, exp_clr);
      check(clr_cnt == 1, "R8 single clear", clr_cnt, 1);
      if (por)
        check(first_req == exp_done && first_boot < 0, "R9 reset request", first_req, exp_done);
      else
        check(first_boot == exp_done && first_req < 0, "R9 boot release", first_boot, exp_done);
    end
    check(!(boot_release_o && reset_req_o) && (boot_release_o || reset_req_o),
          "R9 sticky exit", {boot_release_o, reset_req_o}, 1);
  endtask

  initial begin
    void'($urandom(32'h0000_5eed));
    // directed corners
    run_case(0, 0, 2, 0, 4, 3, 0, 1);   // R2 cool, flag ignored when not enabled
    run_case(0, 0, 1, 1, 3, 2, 1, 1);   // R3 flag alone holds
    run_case(5, 0, 0, 0, 4, 3, 0, 0);   // R4
    run_case(5, 0, 3, 1, 2, 3, 0, 0);   // R4 alt code
    run_case(5, 0, 1, 0, 4, 3, 0, 0);   // R5
    run_case(7, 0, 2, 0, 5, 3, 0, 0);   // R6
    run_case(4, 0, 2, 1, 3, 0, 0, 0);   // R6 interval zero
    run_case(3, 0, 2, 0, 0, 1, 0, 0);   // R7 settle zero
    run_case(3, 3, 2, 0, 6, 4, 0, 0);   // R7 glitch restarts count
    run_case(2, 1, 1, 1, 2, 2, 0, 0);   // R7 single-cycle gap
    for (int k = 0; k < 40; k++) begin
      int h, g, s;
      h = $urandom_range(0, 12);
      s = $urandom_range(0, 10);
      g = (h > 0 && s > 1 && $urandom_range(0, 1) == 1) ? $urandom_range(1, s - 1) : 0;
      wd_backoff_tmo_i = TMO_W'($urandom_range(1, 65535));
      wd_normal_tmo_i  = TMO_W'($urandom_range(1, 65535));
      run_case(h, g, $urandom_range(0, 3), 1'($urandom_range(0, 1)), s,
               $urandom_range(0, 6), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule